// File: doc/BRIEF.md
# Special Bus Cycle Decoder and Acknowledger

This block is system-side logic that watches the bus of a 32-bit processor for special cycles. A special cycle is a bus cycle with the memory/IO, data/control and write/read definition signals set to 0, 0 and 1. The processor uses these cycles to announce an internal event, and it does not move on until the cycle has been acknowledged. The event is encoded in the active-low byte enables and, for one case, in a single address bit. The data bus carries nothing meaningful during these cycles, so the block has no data input.

Each special cycle that the address strobe samples is classified and then completed with a single active-low ready. While that ready is asserted, a one-clock pulse names the event: halt, shutdown, stop-grant, cache flush or write-back. The block keeps three status flags. The halted flag clears when the processor wakes. The stop-granted flag is raised only after the acknowledge has been given. The error flag is sticky and records a special cycle whose encoding matched no known event. Such a cycle is still acknowledged so that the bus cannot hang.

Internally, a classifier decodes the cycle without any storage. A three-state machine then sequences the acknowledge. Its states are ST_IDLE, the optional ST_WAIT and ST_ACK, and its transitions are:

- ST_IDLE to ST_WAIT or ST_ACK when the strobe samples a special cycle.
- ST_WAIT to ST_ACK when its wait count runs out.
- ST_ACK to ST_IDLE after one clock.

A status unit updates the flags on the edge that ends ST_ACK.

Top module: `spc_ack_unit`

## Requirements
- R1: A strobed cycle is acknowledged only when mio=0, dc=0 and wr=1. Any other combination gets no ready, raises no pulse and does not set the halted flag.
- R2: A special cycle with be_n=4'b1011 and the address all zero is a halt. It raises halt_pulse.
- R3: A special cycle with be_n=4'b1110 and the address all zero is a shutdown. It raises shut_pulse.
- R4: A special cycle with be_n=4'b1011 and address 32'h0000_0010 (only bit 4 high) is a stop-grant. It raises sgnt_pulse and not halt_pulse.
- R5: At address zero, be_n=4'b1101 raises flush_pulse and be_n=4'b0111 raises wb_pulse.
- R6: Ready is driven low for exactly one clock. That clock is the ACK_WAIT-th clock period after the edge that sampled the strobe. The event pulse lies in that same clock. Strobes that arrive before the acknowledge has finished are ignored.
- R7: halted is set on the edge that ends a halt acknowledge. It clears on the next edge at which irq_en or nmi_req is high.
- R8: stop_granted is still 0 while the stop-grant ready is low and reads 1 after that clock. It clears when the strobe samples a non-special cycle.
- R9: A special cycle that matches no pattern in R2 to R5 is acknowledged as in R6 with no pulse. It sets bad_cycle, which stays set until reset.
- R10: While rst_n is low, rdy_n is 1, all pulses are 0 and halted, stop_granted and bad_cycle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Active-low address strobe |
| mio | input | 1 | Memory (1) or IO (0) definition |
| dc | input | 1 | Data (1) or control (0) definition |
| wr | input | 1 | Write (1) or read (0) definition |
| addr | input | ADDR_W | Processor address bus |
| be_n | input | 4 | Active-low byte enables, bit 0 is byte 0 |
| irq_en | input | 1 | Interrupt request that the processor accepts |
| nmi_req | input | 1 | Non-maskable interrupt request |
| rdy_n | output | 1 | Active-low non-burst ready |
| halt_pulse | output | 1 | Halt announced |
| shut_pulse | output | 1 | Shutdown announced |
| sgnt_pulse | output | 1 | Stop-grant announced |
| flush_pulse | output | 1 | External cache flush request |
| wb_pulse | output | 1 | External cache write-back request |
| halted | output | 1 | Processor is in the halt state |
| stop_granted | output | 1 | Processor has entered stop-grant |
| bad_cycle | output | 1 | Sticky flag for an unrecognised special cycle |

## Verification
The bench builds the block with ADDR_W=32, SGNT_BIT=4 and ACK_WAIT=2. With that setting ST_WAIT is on the path, so the delay between strobe and ready is longer than one clock. A second strobe sent during the wait state can then show that the block ignores strobes while it is busy. The stop-grant address, which differs from halt in one bit, and a near-miss at bit 2 both pass through the decoder at full bus width. This shows that the error path and the stop-grant path are told apart by the address alone.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int BE_W   = 4;
    localparam int NUM_EV = 5;

    // byte-enable codes, active low
    localparam logic [BE_W-1:0] BE_HALT_SGNT = 4'b1011;
    localparam logic [BE_W-1:0] BE_SHUT      = 4'b1110;
    localparam logic [BE_W-1:0] BE_FLUSH     = 4'b1101;
    localparam logic [BE_W-1:0] BE_WB        = 4'b0111;

    // the first NUM_EV values index the event pulse vector
    typedef enum logic [2:0] {
        SK_HALT  = 3'd0,
        SK_SHUT  = 3'd1,
        SK_SGNT  = 3'd2,
        SK_FLUSH = 3'd3,
        SK_WB    = 3'd4,
        SK_BAD   = 3'd5
    } spc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } spc_state_e;

endpackage

// File: rtl/spc_classify.sv
module spc_classify
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SGNT_BIT = 4
) (
    input  logic              mio,
    input  logic              dc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be_n,
    output logic              is_special,
    output spc_kind_e         kind
);

    localparam logic [ADDR_W-1:0] SGNT_ADDR = ADDR_W'(1) << SGNT_BIT;

    logic addr_zero;
    logic addr_sgnt;

    always_comb begin
        is_special = !mio && !dc && wr;
        addr_zero  = (addr == '0);
        addr_sgnt  = (addr == SGNT_ADDR);
        kind       = SK_BAD;
        unique case (be_n)
            BE_HALT_SGNT: begin
                if (addr_zero)      kind = SK_HALT;
                else if (addr_sgnt) kind = SK_SGNT;
            end
            BE_SHUT:  if (addr_zero) kind = SK_SHUT;
            BE_FLUSH: if (addr_zero) kind = SK_FLUSH;
            BE_WB:    if (addr_zero) kind = SK_WB;
            default:  kind = SK_BAD;
        endcase
    end

endmodule

// File: rtl/spc_ack_fsm.sv
module spc_ack_fsm
    import spc_pkg::*;
#(
    parameter int ACK_WAIT = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ads_n,
    input  logic      is_special,
    input  spc_kind_e kind_in,
    output logic      rdy_n,
    output logic      ack_now,
    output spc_kind_e kind_q
);

    localparam int WAIT_LOAD = (ACK_WAIT > 1) ? ACK_WAIT - 2 : 0;
    localparam int CW        = (ACK_WAIT > 2) ? $clog2(ACK_WAIT) : 1;

    spc_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    spc_kind_e kind_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            kind_q <= SK_BAD;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            kind_q <= kind_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        kind_nx  = kind_q;
        unique case (state)
            ST_IDLE: begin
                if (!ads_n && is_special) begin
                    kind_nx = kind_in;
                    if (ACK_WAIT > 1) begin
                        state_nx = ST_WAIT;
                        cnt_nx   = CW'(WAIT_LOAD);
                    end else begin
                        state_nx = ST_ACK;
                    end
                end
            end
            ST_WAIT: begin
                if (cnt == '0) state_nx = ST_ACK;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack_now = (state == ST_ACK);
        rdy_n   = !ack_now;
    end

endmodule

// File: rtl/spc_status.sv
module spc_status
    import spc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_now,
    input  spc_kind_e kind_q,
    input  logic      ads_n,
    input  logic      is_special,
    input  logic      irq_en,
    input  logic      nmi_req,
    output logic      halted,
    output logic      stop_granted,
    output logic      bad_cycle
);

    logic wake;
    logic plain_strobe;

    always_comb begin
        wake         = irq_en || nmi_req;
        plain_strobe = !ads_n && !is_special;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted       <= 1'b0;
            stop_granted <= 1'b0;
            bad_cycle    <= 1'b0;
        end else begin
            if (ack_now && kind_q == SK_HALT) halted <= 1'b1;
            else if (wake)                    halted <= 1'b0;

            if (ack_now && kind_q == SK_SGNT) stop_granted <= 1'b1;
            else if (plain_strobe)            stop_granted <= 1'b0;

            if (ack_now && kind_q == SK_BAD)  bad_cycle <= 1'b1;
        end
    end

endmodule

// File: rtl/spc_ack_unit.sv
module spc_ack_unit
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SGNT_BIT = 4,
    parameter int ACK_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic              mio,
    input  logic              dc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be_n,
    input  logic              irq_en,
    input  logic              nmi_req,
    output logic              rdy_n,
    output logic              halt_pulse,
    output logic              shut_pulse,
    output logic              sgnt_pulse,
    output logic              flush_pulse,
    output logic              wb_pulse,
    output logic              halted,
    output logic              stop_granted,
    output logic              bad_cycle
);

    logic      is_special;
    spc_kind_e kind_dec;
    spc_kind_e kind_q;
    logic      ack_now;
    logic [NUM_EV-1:0] ev;

    spc_classify #(
        .ADDR_W   (ADDR_W),
        .SGNT_BIT (SGNT_BIT)
    ) u_classify (
        .mio        (mio),
        .dc         (dc),
        .wr         (wr),
        .addr       (addr),
        .be_n       (be_n),
        .is_special (is_special),
        .kind       (kind_dec)
    );

    spc_ack_fsm #(
        .ACK_WAIT (ACK_WAIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ads_n      (ads_n),
        .is_special (is_special),
        .kind_in    (kind_dec),
        .rdy_n      (rdy_n),
        .ack_now    (ack_now),
        .kind_q     (kind_q)
    );

    spc_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_now      (ack_now),
        .kind_q       (kind_q),
        .ads_n        (ads_n),
        .is_special   (is_special),
        .irq_en       (irq_en),
        .nmi_req      (nmi_req),
        .halted       (halted),
        .stop_granted (stop_granted),
        .bad_cycle    (bad_cycle)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        assign ev[i] = ack_now && (kind_q == spc_kind_e'(3'(i)));
    end

    always_comb begin
        halt_pulse  = ev[SK_HALT];
        shut_pulse  = ev[SK_SHUT];
        sgnt_pulse  = ev[SK_SGNT];
        flush_pulse = ev[SK_FLUSH];
        wb_pulse    = ev[SK_WB];
    end

endmodule

// File: rtl/spc_ack_chk.sv
module spc_ack_chk (
    input logic clk,
    input logic rst_n,
    input logic rdy_n,
    input logic halt_pulse,
    input logic shut_pulse,
    input logic sgnt_pulse,
    input logic flush_pulse,
    input logic wb_pulse,
    input logic halted,
    input logic stop_granted,
    input logic bad_cycle,
    input logic irq_en,
    input logic nmi_req
);

    logic [4:0] pulses;
    assign pulses = {wb_pulse, flush_pulse, sgnt_pulse, shut_pulse, halt_pulse};

    // R6
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |=> rdy_n);

    // R6
    pulse_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 5'b0) |-> !rdy_n);

    // R5
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    // R7
    halt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(!rdy_n));

    // R7
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && (irq_en || nmi_req) && rdy_n) |=> !halted);

    // R8
    sgnt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_granted) |-> $past(!rdy_n));

    // R9
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cycle |=> bad_cycle);

endmodule

bind spc_ack_unit spc_ack_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy_n        (rdy_n),
    .halt_pulse   (halt_pulse),
    .shut_pulse   (shut_pulse),
    .sgnt_pulse   (sgnt_pulse),
    .flush_pulse  (flush_pulse),
    .wb_pulse     (wb_pulse),
    .halted       (halted),
    .stop_granted (stop_granted),
    .bad_cycle    (bad_cycle),
    .irq_en       (irq_en),
    .nmi_req      (nmi_req)
);

// File: tb/tb_spc_ack_unit.sv
`timescale 1ns/1ps
module tb_spc_ack_unit;

    localparam int ACK_WAIT = 2;
    localparam logic [4:0] P_HALT = 5'b00001;
    localparam logic [4:0] P_SHUT = 5'b00010;
    localparam logic [4:0] P_SGNT = 5'b00100;
    localparam logic [4:0] P_FL   = 5'b01000;
    localparam logic [4:0] P_WB   = 5'b10000;
    localparam logic [4:0] P_NONE = 5'b00000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ads_n = 1'b1, mio = 1'b1, dc = 1'b1, wr = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic irq_en = 1'b0, nmi_req = 1'b0;
    logic rdy_n, halt_pulse, shut_pulse, sgnt_pulse, flush_pulse, wb_pulse;
    logic halted, stop_granted, bad_cycle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         due;
        logic [4:0] pulses;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spc_ack_unit #(.ADDR_W(32), .SGNT_BIT(4), .ACK_WAIT(ACK_WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
        .addr(addr), .be_n(be_n), .irq_en(irq_en), .nmi_req(nmi_req),
        .rdy_n(rdy_n), .halt_pulse(halt_pulse), .shut_pulse(shut_pulse),
        .sgnt_pulse(sgnt_pulse), .flush_pulse(flush_pulse), .wb_pulse(wb_pulse),
        .halted(halted), .stop_granted(stop_granted), .bad_cycle(bad_cycle)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: every ready must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rdy_n === 1'b0) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 unexpected ready act=0 exp=1");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " ready cycle"}, cyc, e.due);
                chk({e.tag, " pulses"},
                    {27'b0, wb_pulse, flush_pulse, sgnt_pulse, shut_pulse, halt_pulse},
                    {27'b0, e.pulses});
                if (e.pulses == P_SGNT)
                    chk("R8 stop_granted during ack", stop_granted, 0);
            end
        end
    end

    task automatic bus_cycle(input logic m, input logic d, input logic w,
                             input logic [31:0] a, input logic [3:0] be,
                             input bit ack, input logic [4:0] ep, input string tag);
        @(negedge clk);
        mio = m; dc = d; wr = w; addr = a; be_n = be; ads_n = 1'b0;
        if (ack) sb.push_back('{due: cyc + ACK_WAIT, pulses: ep, tag: tag});
        @(negedge clk);
        ads_n = 1'b1; mio = 1'b1; dc = 1'b1; addr = 32'hFFFF_FFFF; be_n = 4'h0;
        repeat (ACK_WAIT + 1) @(negedge clk);
    endtask

    task automatic pulse_in(input bit use_nmi);
        @(negedge clk);
        if (use_nmi) nmi_req = 1'b1; else irq_en = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0; irq_en = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rdy_n", rdy_n, 1);
        chk("R10 pulses", {wb_pulse, flush_pulse, sgnt_pulse, shut_pulse, halt_pulse}, 0);
        chk("R10 flags", {halted, stop_granted, bad_cycle}, 0);
        rst_n = 1'b1;

        // R2 halt, R7 wake by interrupt
        bus_cycle(0, 0, 1, 32'h0, 4'b1011, 1, P_HALT, "R2 halt");
        chk("R7 halted set", halted, 1);
        pulse_in(0);
        chk("R7 irq clears halted", halted, 0);

        // R7 wake by nmi
        bus_cycle(0, 0, 1, 32'h0, 4'b1011, 1, P_HALT, "R2 halt again");
        chk("R7 halted set again", halted, 1);
        pulse_in(1);
        chk("R7 nmi clears halted", halted, 0);

        // R3 shutdown, R5 flush and write-back
        bus_cycle(0, 0, 1, 32'h0, 4'b1110, 1, P_SHUT, "R3 shutdown");
        bus_cycle(0, 0, 1, 32'h0, 4'b1101, 1, P_FL, "R5 flush");
        bus_cycle(0, 0, 1, 32'h0, 4'b0111, 1, P_WB, "R5 writeback");
        chk("R3 no halt from shutdown", halted, 0);

        // R4 stop-grant, R8 flag after ack
        bus_cycle(0, 0, 1, 32'h10, 4'b1011, 1, P_SGNT, "R4 stop-grant");
        chk("R8 stop_granted set", stop_granted, 1);
        chk("R4 not halted", halted, 0);

        // R1 non-special with halt pattern: no ack, clears stop_granted
        bus_cycle(1, 0, 1, 32'h0, 4'b1011, 0, P_NONE, "R1 memory");
        chk("R8 plain strobe clears", stop_granted, 0);
        chk("R1 memory no halt", halted, 0);
        bus_cycle(0, 0, 0, 32'h0, 4'b1011, 0, P_NONE, "R1 read");
        chk("R1 read no halt", halted, 0);

        // R6 second strobe during the wait state is ignored
        @(negedge clk);
        mio = 0; dc = 0; wr = 1; addr = 32'h0; be_n = 4'b1011; ads_n = 1'b0;
        sb.push_back('{due: cyc + ACK_WAIT, pulses: P_HALT, tag: "R6 first strobe"});
        @(negedge clk);
        be_n = 4'b1110;
        @(negedge clk);
        ads_n = 1'b1; mio = 1'b1; dc = 1'b1;
        repeat (ACK_WAIT + 2) @(negedge clk);
        chk("R6 busy strobe dropped", sb.size(), 0);
        pulse_in(0);

        // R9 unknown encoding: bit 2 near-miss
        bus_cycle(0, 0, 1, 32'h4, 4'b1011, 1, P_NONE, "R9 unknown");
        chk("R9 bad set", bad_cycle, 1);
        chk("R9 no halt", halted, 0);
        bus_cycle(0, 0, 1, 32'h0, 4'b1110, 1, P_SHUT, "R9 after bad");
        chk("R9 bad sticky", bad_cycle, 1);

        // R10 reset clears flags
        bus_cycle(0, 0, 1, 32'h0, 4'b1011, 1, P_HALT, "R10 pre-reset halt");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 flags cleared", {halted, stop_granted, bad_cycle}, 0);
        chk("R10 rdy_n high", rdy_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk("R6 scoreboard drained", sb.size(), 0);
        summary();
        $finish;
    end

endmodule